// File: doc/BRIEF.md
# Hamming (7,4) Single-Error-Correcting Codec

This block protects a 4-bit data path with a (7,4) linear block code. Two independent streaming paths share one clock. The encode path takes a 4-bit word and emits a 7-bit codeword: the four data bits first, then three check bits. The decode path takes a 7-bit received word and computes a 3-bit syndrome. When the syndrome is non-zero, it inverts the one bit whose check pattern matches the syndrome. It then emits the repaired 4-bit data together with a flag that marks a corrected word.

Each path is a single registered stage with a valid/ready handshake. A word moves into a stage on a rising edge where valid and ready are both high. A stage can accept a new word when it is empty or when its current output is taken in the same cycle. When the consumer holds ready low, the stage keeps its output and valid steady and drops its own input ready until the output is taken. A producer must keep valid and data steady while ready is low.

Top module: `ham74_codec`

## Requirements
- R1: The encoder copies the data into the top of the codeword. Data bit 3 (D1) goes to code bit 6, bit 2 (D2) to code bit 5, bit 1 (D3) to code bit 4 and bit 0 (D4) to code bit 3.
- R2: The encoder check bits are code bit 2 = D1^D3^D4, code bit 1 = D1^D2^D4 and code bit 0 = D1^D2^D3.
- R3: A word accepted on a rising edge appears with out_valid high after that same edge. This gives one cycle of latency on each path.
- R4: While out_valid is high and out_ready is low, the output word and valid stay unchanged and in_ready is low. The held word is delivered first once out_ready rises.
- R5: A synchronous active-high reset clears out_valid on both paths and discards a held word.
- R6: A received word with a zero syndrome is output unchanged in data (code bits 6..3) with the error flag low. The syndrome bits (s1,s2,s3) are the three check equations of R2, each XORed with its received check bit.
- R7: A single inverted bit at any of the seven positions is repaired and raises the error flag for that one output word. The syndrome is 111 for code bit 6, 011 for bit 5, 101 for bit 4, 110 for bit 3, 100 for bit 2, 010 for bit 1 and 001 for bit 0. A hit on a check bit leaves the data as sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enc_in_valid | input | 1 | Data word offered to encoder |
| enc_in_ready | output | 1 | Encoder can take a word |
| enc_in_data | input | 4 | Data word, bit 3 = D1 |
| enc_out_valid | output | 1 | Codeword available |
| enc_out_ready | input | 1 | Consumer takes codeword |
| enc_out_code | output | 7 | Codeword, bit 6 = D1, bit 0 = third check |
| dec_in_valid | input | 1 | Received word offered to decoder |
| dec_in_ready | output | 1 | Decoder can take a word |
| dec_in_code | input | 7 | Received word, same layout as encoder output |
| dec_out_valid | output | 1 | Repaired data available |
| dec_out_ready | input | 1 | Consumer takes repaired data |
| dec_out_data | output | 4 | Repaired data word |
| dec_out_err | output | 1 | A bit was inverted to repair this word |

## Verification
Both results are due exactly one cycle after acceptance. The bench drives each word on a falling edge, lets one rising edge load it, and compares at the next falling edge, where the registered output has settled. For back-pressure, the held codeword is compared again on later falling edges while ready is low. The queued word is then expected one rising edge after ready returns. A reset applied to a held word is judged one edge after it is sampled.

// File: rtl/ham74_pkg.sv
package ham74_pkg;
  localparam int DATA_W = 4;
  localparam int CHK_W  = 3;
  localparam int CODE_W = DATA_W + CHK_W;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CHK_W-1:0]  chk_t;
  typedef logic [CODE_W-1:0] code_t;

  // Check bits {c1,c2,c3} for data {D1,D2,D3,D4} = d[3:0]
  function automatic chk_t check_bits(data_t d);
    chk_t c;
    c[2] = d[3] ^ d[1] ^ d[0];
    c[1] = d[3] ^ d[2] ^ d[0];
    c[0] = d[3] ^ d[2] ^ d[1];
    return c;
  endfunction

  // Syndrome {s1,s2,s3} of a received codeword
  function automatic chk_t syndrome_of(code_t w);
    return check_bits(w[CODE_W-1:CHK_W]) ^ w[CHK_W-1:0];
  endfunction

  // Check column of each codeword position, position 6 = D1 .. 0 = c3
  function automatic chk_t column_of(int pos);
    chk_t col;
    case (pos)
      6: col = 3'b111;
      5: col = 3'b011;
      4: col = 3'b101;
      3: col = 3'b110;
      2: col = 3'b100;
      1: col = 3'b010;
      default: col = 3'b001;
    endcase
    return col;
  endfunction
endpackage

// File: rtl/ham74_stage.sv
module ham74_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R4: stalled output is held
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R3: an accepted word is presented on the next cycle
  p_accept_next_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data));
endmodule

// File: rtl/ham74_encoder.sv
module ham74_encoder
  import ham74_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  output logic  in_ready,
  input  data_t in_data,
  output logic  out_valid,
  input  logic  out_ready,
  output code_t out_code
);
  code_t next_code;

  always_comb begin
    next_code = {in_data, check_bits(in_data)};
  end

  ham74_stage #(.WIDTH(CODE_W)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (next_code),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_code)
  );

  // R2: every emitted codeword has a zero syndrome
  p_clean_code_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> syndrome_of(out_code) == '0);
endmodule

// File: rtl/ham74_decoder.sv
module ham74_decoder
  import ham74_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  output logic  in_ready,
  input  code_t in_code,
  output logic  out_valid,
  input  logic  out_ready,
  output data_t out_data,
  output logic  out_err
);
  chk_t  syn;
  code_t flip;
  code_t fixed;
  logic [DATA_W:0] stage_in, stage_out;

  assign syn = syndrome_of(in_code);

  // one comparator per codeword position
  for (genvar p = 0; p < CODE_W; p++) begin : g_col
    assign flip[p] = (syn == column_of(p));
  end

  assign fixed    = in_code ^ flip;
  assign stage_in = {(syn != '0), fixed[CODE_W-1:CHK_W]};

  ham74_stage #(.WIDTH(DATA_W + 1)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (stage_in),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (stage_out)
  );

  assign out_err  = stage_out[DATA_W];
  assign out_data = stage_out[DATA_W-1:0];

  // R7: the repaired word always satisfies all checks
  p_fixed_clean_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> syndrome_of(fixed) == '0);

  // R7: at most one bit is inverted
  p_one_flip_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> $onehot0(flip));

  // R6: a clean word passes with no flag
  p_clean_pass_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && syn == '0 |=> !out_err &&
      out_data == $past(in_code[CODE_W-1:CHK_W]));
endmodule

// File: rtl/ham74_codec.sv
module ham74_codec
  import ham74_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enc_in_valid,
  output logic       enc_in_ready,
  input  logic [3:0] enc_in_data,
  output logic       enc_out_valid,
  input  logic       enc_out_ready,
  output logic [6:0] enc_out_code,
  input  logic       dec_in_valid,
  output logic       dec_in_ready,
  input  logic [6:0] dec_in_code,
  output logic       dec_out_valid,
  input  logic       dec_out_ready,
  output logic [3:0] dec_out_data,
  output logic       dec_out_err
);
  ham74_encoder u_enc (
    .clk      (clk),
    .rst      (rst),
    .in_valid (enc_in_valid),
    .in_ready (enc_in_ready),
    .in_data  (enc_in_data),
    .out_valid(enc_out_valid),
    .out_ready(enc_out_ready),
    .out_code (enc_out_code)
  );

  ham74_decoder u_dec (
    .clk      (clk),
    .rst      (rst),
    .in_valid (dec_in_valid),
    .in_ready (dec_in_ready),
    .in_code  (dec_in_code),
    .out_valid(dec_out_valid),
    .out_ready(dec_out_ready),
    .out_data (dec_out_data),
    .out_err  (dec_out_err)
  );
endmodule

// File: tb/tb_ham74_codec.sv
module tb_ham74_codec;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enc_in_valid = 1'b0, enc_out_ready = 1'b1;
  logic [3:0] enc_in_data = '0;
  logic       dec_in_valid = 1'b0, dec_out_ready = 1'b1;
  logic [6:0] dec_in_code = '0;
  logic       enc_in_ready, enc_out_valid, dec_in_ready, dec_out_valid, dec_out_err;
  logic [6:0] enc_out_code;
  logic [3:0] dec_out_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  ham74_codec dut (.*);

  function automatic logic [6:0] ref_code(logic [3:0] d);
    logic d1, d2, d3, d4;
    d1 = d[3]; d2 = d[2]; d3 = d[1]; d4 = d[0];
    return {d1, d2, d3, d4, d1 ^ d3 ^ d4, d1 ^ d2 ^ d4, d1 ^ d2 ^ d3};
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      summary();
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R5: reset state
    check(!enc_out_valid && !dec_out_valid, "R5 reset valid", {enc_out_valid, dec_out_valid}, 0);
    check(enc_in_ready && dec_in_ready, "R5 reset ready", {enc_in_ready, dec_in_ready}, 3);
    rst = 1'b0;

    // R1 R2 R3: exhaustive encode
    for (int d = 0; d < 16; d++) begin
      enc_in_valid = 1'b1;
      enc_in_data  = 4'(d);
      @(negedge clk);
      check(enc_out_valid, "R3 enc valid", enc_out_valid, 1);
      check(enc_out_code[6:3] == 4'(d), "R1 enc data", enc_out_code[6:3], d);
      check(enc_out_code == ref_code(4'(d)), "R2 enc parity", enc_out_code, ref_code(4'(d)));
    end
    enc_in_valid = 1'b0;
    @(negedge clk);
    check(!enc_out_valid, "R3 enc drain", enc_out_valid, 0);

    // R6 R7: every data word, clean and with each single-bit error
    for (int d = 0; d < 16; d++) begin
      for (int k = 0; k < 8; k++) begin
        logic [6:0] w;
        w = ref_code(4'(d));
        if (k < 7) w[k] = ~w[k];
        dec_in_valid = 1'b1;
        dec_in_code  = w;
        @(negedge clk);
        check(dec_out_valid, "R3 dec valid", dec_out_valid, 1);
        if (k == 7) begin
          check(dec_out_data == 4'(d), "R6 clean data", dec_out_data, d);
          check(!dec_out_err, "R6 clean flag", dec_out_err, 0);
        end else begin
          check(dec_out_data == 4'(d), "R7 fixed data", dec_out_data, d);
          check(dec_out_err, "R7 err flag", dec_out_err, 1);
        end
      end
    end
    dec_in_valid = 1'b0;
    @(negedge clk);
    check(!dec_out_valid, "R7 flag one word only", dec_out_valid, 0);

    // R4: back-pressure on encoder
    enc_out_ready = 1'b0;
    enc_in_valid  = 1'b1;
    enc_in_data   = 4'h9;
    @(negedge clk);
    check(enc_out_valid && enc_out_code == ref_code(4'h9), "R4 first word", enc_out_code, ref_code(4'h9));
    check(!enc_in_ready, "R4 ready low", enc_in_ready, 0);
    enc_in_data = 4'h6;
    @(negedge clk);
    check(enc_out_valid && enc_out_code == ref_code(4'h9), "R4 hold", enc_out_code, ref_code(4'h9));
    check(!enc_in_ready, "R4 ready still low", enc_in_ready, 0);
    enc_out_ready = 1'b1;
    @(negedge clk);
    check(enc_out_valid && enc_out_code == ref_code(4'h6), "R4 queued word", enc_out_code, ref_code(4'h6));
    enc_in_valid = 1'b0;
    @(negedge clk);
    check(!enc_out_valid, "R4 drained", enc_out_valid, 0);

    // R4: back-pressure on decoder
    dec_out_ready = 1'b0;
    dec_in_valid  = 1'b1;
    dec_in_code   = ref_code(4'hC) ^ 7'b0000100;
    @(negedge clk);
    dec_in_code = ref_code(4'h3);
    @(negedge clk);
    check(dec_out_valid && dec_out_data == 4'hC && dec_out_err, "R4 dec hold",
          {dec_out_err, dec_out_data}, 5'h1C);
    check(!dec_in_ready, "R4 dec ready low", dec_in_ready, 0);
    dec_out_ready = 1'b1;
    @(negedge clk);
    check(dec_out_data == 4'h3 && !dec_out_err, "R4 dec queued", {dec_out_err, dec_out_data}, 5'h03);
    dec_in_valid = 1'b0;

    // R5: reset discards a held word
    enc_out_ready = 1'b0;
    enc_in_valid  = 1'b1;
    enc_in_data   = 4'hA;
    @(negedge clk);
    enc_in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(!enc_out_valid && !dec_out_valid, "R5 mid reset", {enc_out_valid, dec_out_valid}, 0);
    rst = 1'b0;
    enc_out_ready = 1'b1;
    @(negedge clk);
    check(!enc_out_valid, "R5 stays empty", enc_out_valid, 0);

    summary();
  end
endmodule